// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is an eight-stage shift register that captures a byte in parallel and sends it out one bit at a time. It lives entirely inside one system-clock domain: the parallel bits, the serial input, an active-low load strobe, a shift clock and an active-low shift enable all arrive as ordinary signals and are sampled on every rising edge of the system clock. A shift happens when the OR of the shift clock and the enable goes from low to high, which lets either pin act as the clock and the other as a hold control.

While the load strobe is low the stages keep copying the parallel inputs, and the serial output shows the top parallel bit immediately. Once the strobe is high, each qualifying edge moves the data one stage toward the output, with the serial input filling stage 0. Wiring the serial output of one instance to the serial input of another extends the chain, so that two instances form a sixteen-stage register.

Top module: `piso_shift8`

## Requirements
- R1: While `load_n` is 0, every stage takes the value of `par_in` on every system clock edge, so the value present at the last edge before release is the one that is shifted out.
- R2: While `load_n` is 0, `tail` equals `par_in[WIDTH-1]` in the same cycle, without waiting for a clock edge, and `tail_n` is its inverse.
- R3: With `load_n` at 1, a low-to-high change of (`sclk` OR `sclk_en_n`) seen at a system clock edge shifts once: stage 0 takes `ser_in` and stage n takes the old stage n-1. The bits leave through `tail` starting with `par_in[WIDTH-1]` and ending with `par_in[0]`.
- R4: While `sclk_en_n` is 1, toggling `sclk` leaves the contents unchanged.
- R5: A rise of `sclk_en_n` while `sclk` is 0 causes exactly one shift.
- R6: Raising `load_n` while both `sclk` and `sclk_en_n` are 0 causes no shift.
- R7: With `load_n` at 1, `tail` shows the last stage and `tail_n` always equals the inverse of `tail`.
- R8: With the `tail` of one instance driving the `ser_in` of a second instance and shared controls, the second instance emits its own loaded byte first, then the first instance's byte, each most-significant bit first.
- R9: Rising edges of (`sclk` OR `sclk_en_n`) that occur while `load_n` is 0 cause no shift.
- R10: A synchronous active-high `rst` clears all stages to 0, and releasing `rst` while (`sclk` OR `sclk_en_n`) is already 1 causes no shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| par_in | input | WIDTH | Parallel data, bit WIDTH-1 leaves first |
| ser_in | input | 1 | Serial data into stage 0 |
| load_n | input | 1 | Parallel load strobe, active low, overrides shifting |
| sclk | input | 1 | Shift clock |
| sclk_en_n | input | 1 | Shift enable, active low, ORed with `sclk` |
| tail | output | 1 | Last stage (or `par_in[WIDTH-1]` during load) |
| tail_n | output | 1 | Inverse of `tail` |

## Verification
The hardest cases to reach are the ones where the shift edge must not happen although a pin moves: the release of the load strobe with the gated clock already low, the release of reset with the gated clock already high, and clock pulses under a held enable. The stimulus arranges the gated clock level before each such event, and then shifts the full register out with a known serial fill, so a spurious extra or missing shift shows up as a misplaced bit. Random bytes are shifted with a random mix of clock-driven and enable-driven edges and hold windows, and a second instance chained to the first checks the sixteen-bit order.

// File: rtl/piso_pkg.sv
package piso_pkg;

    // What the register does on a given system clock edge.
    typedef enum logic [1:0] {
        PISO_HOLD  = 2'd0,
        PISO_SHIFT = 2'd1,
        PISO_LOAD  = 2'd2
    } piso_mode_e;

    // Load wins over any gated-clock edge.
    function automatic piso_mode_e pick_mode(input logic load_n, input logic gate_rise);
        if (!load_n)
            return PISO_LOAD;
        else if (gate_rise)
            return PISO_SHIFT;
        else
            return PISO_HOLD;
    endfunction

endpackage

// File: rtl/piso_gate_edge.sv
module piso_gate_edge (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic sclk_en_n,
    output logic gate_rise
);

    typedef struct packed {
        logic gate;
    } edge_state_t;

    logic        gate_now;
    edge_state_t st_d;
    edge_state_t st_q;

    // Either pin may serve as clock; the other holds the level high to inhibit.
    assign gate_now = sclk | sclk_en_n;

    always_comb begin
        st_d      = st_q;
        st_d.gate = gate_now;
        gate_rise = gate_now & ~st_q.gate & ~rst;
    end

    // History starts at the present level so reset release is never an edge.
    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

endmodule

// File: rtl/piso_stage_chain.sv
module piso_stage_chain
    import piso_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  piso_mode_e       mode,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    output logic [WIDTH-1:0] stage_q
);

    typedef struct packed {
        logic [WIDTH-1:0] stages;
    } chain_state_t;

    chain_state_t st_d;
    chain_state_t st_q;
    logic [WIDTH-1:0] shifted;

    // Stage 0 takes the serial bit, every other stage its lower neighbour.
    assign shifted[0] = ser_in;
    for (genvar g = 1; g < WIDTH; g++) begin : g_link
        assign shifted[g] = st_q.stages[g-1];
    end

    always_comb begin
        st_d = st_q;
        unique case (mode)
            PISO_LOAD:  st_d.stages = par_in;
            PISO_SHIFT: st_d.stages = shifted;
            default:    st_d.stages = st_q.stages;
        endcase
        if (rst)
            st_d.stages = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign stage_q = st_q.stages;

endmodule

// File: rtl/piso_tail_drive.sv
module piso_tail_drive (
    input  logic load_n,
    input  logic par_top,
    input  logic last_stage,
    output logic tail,
    output logic tail_n
);

    // During load the top parallel bit passes straight through.
    always_comb begin
        tail   = load_n ? last_stage : par_top;
        tail_n = ~tail;
    end

endmodule

// File: rtl/piso_shift8.sv
module piso_shift8
    import piso_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    input  logic             load_n,
    input  logic             sclk,
    input  logic             sclk_en_n,
    output logic             tail,
    output logic             tail_n
);

    localparam int TOP = WIDTH - 1;

    logic             gate_rise;
    piso_mode_e       mode;
    logic [WIDTH-1:0] stage_q;

    piso_gate_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .sclk      (sclk),
        .sclk_en_n (sclk_en_n),
        .gate_rise (gate_rise)
    );

    assign mode = pick_mode(load_n, gate_rise);

    piso_stage_chain #(.WIDTH(WIDTH)) u_chain (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .par_in  (par_in),
        .ser_in  (ser_in),
        .stage_q (stage_q)
    );

    piso_tail_drive u_tail (
        .load_n     (load_n),
        .par_top    (par_in[TOP]),
        .last_stage (stage_q[TOP]),
        .tail       (tail),
        .tail_n     (tail_n)
    );

endmodule

// File: rtl/piso_shift8_chk.sv
module piso_shift8_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] par_in,
    input logic             ser_in,
    input logic             load_n,
    input logic             sclk,
    input logic             sclk_en_n,
    input logic             tail,
    input logic             tail_n,
    input logic [WIDTH-1:0] stages
);

    logic gate;
    assign gate = sclk | sclk_en_n;

    // R1
    load_copy_chk: assert property (@(posedge clk) disable iff (rst)
        !load_n |=> stages == $past(par_in));

    // R2
    load_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !load_n |-> tail == par_in[WIDTH-1]);

    // R3
    shift_chk: assert property (@(posedge clk) disable iff (rst)
        (load_n && gate && !$past(gate)) |=>
            stages == {$past(stages[WIDTH-2:0]), $past(ser_in)});

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (load_n && !(gate && !$past(gate))) |=> $stable(stages));

    // R7
    tail_stage_chk: assert property (@(posedge clk) disable iff (rst)
        load_n |-> tail == stages[WIDTH-1]);

    // R7
    tail_compl_chk: assert property (@(posedge clk) disable iff (rst)
        tail_n != tail);

endmodule

bind piso_shift8 piso_shift8_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .par_in    (par_in),
    .ser_in    (ser_in),
    .load_n    (load_n),
    .sclk      (sclk),
    .sclk_en_n (sclk_en_n),
    .tail      (tail),
    .tail_n    (tail_n),
    .stages    (stage_q)
);

// File: tb/tb_piso_shift8.sv
`timescale 1ns/1ps
module tb_piso_shift8;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] par_a, par_b;
    logic       ser_in, load_n, sclk, sclk_en_n;
    logic       tail_a, tail_an, tail_b, tail_bn;

    int total = 0;
    int bad   = 0;
    logic q_a[$];
    logic q_b[$];

    always #10 clk = ~clk;

    piso_shift8 #(.WIDTH(8)) dut (
        .clk(clk), .rst(rst), .par_in(par_a), .ser_in(ser_in), .load_n(load_n),
        .sclk(sclk), .sclk_en_n(sclk_en_n), .tail(tail_a), .tail_n(tail_an)
    );

    // second instance chained behind the first
    piso_shift8 #(.WIDTH(8)) dut2 (
        .clk(clk), .rst(rst), .par_in(par_b), .ser_in(tail_a), .load_n(load_n),
        .sclk(sclk), .sclk_en_n(sclk_en_n), .tail(tail_b), .tail_n(tail_bn)
    );

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // expected tails from the reference queues
    task automatic check_tails(input string req);
        check(req, tail_a, q_a[0]);
        check("R7", tail_an, ~q_a[0]);
        check({req, " R8"}, tail_b, q_b[0]);
    endtask

    function automatic void model_shift(input logic s);
        logic h;
        h = q_a.pop_front();
        q_a.push_back(s);
        void'(q_b.pop_front());
        q_b.push_back(h);
    endfunction

    task automatic do_load(input logic [7:0] a, input logic [7:0] b);
        sclk = 1'b0; sclk_en_n = 1'b0;
        load_n = 1'b0;
        par_a = ~a; par_b = ~b;
        #1;
        check("R2", tail_a, ~a[7]);
        check("R2", tail_an, a[7]);
        step();
        // gated-clock edges during load are ignored (R9)
        sclk = 1'b1; step();
        sclk = 1'b0; step();
        par_a = a; par_b = b;
        #1;
        check("R2", tail_a, a[7]);
        check("R2", tail_b, b[7]);
        step();
        // release with gated clock low: no shift (R6)
        load_n = 1'b1;
        step();
        q_a.delete(); q_b.delete();
        for (int i = 7; i >= 0; i--) begin
            q_a.push_back(a[i]);
            q_b.push_back(b[i]);
        end
        check_tails("R6");
    endtask

    // kind 0: clock edge; kind 1: enable edge while clock low
    task automatic shift_once(input int kind, input logic s);
        ser_in = s;
        if (kind == 0) begin
            sclk = 1'b1; step();
            model_shift(s);
            check_tails("R3");
            ser_in = ~s;
            sclk = 1'b0; step();
            check_tails("R3");
        end else begin
            sclk_en_n = 1'b1; step();
            model_shift(s);
            check_tails("R5");
            ser_in = ~s;
            sclk_en_n = 1'b0; step();
            check_tails("R5");
        end
    endtask

    // one clock-edge shift, then enable held high while clock toggles
    task automatic hold_window(input logic s, input int pulses);
        ser_in = s;
        sclk = 1'b1; step();
        model_shift(s);
        check_tails("R3");
        sclk_en_n = 1'b1; step();
        for (int p = 0; p < pulses; p++) begin
            ser_in = ~ser_in;
            sclk = 1'b0; step();
            sclk = 1'b1; step();
            check_tails("R4");
        end
        sclk_en_n = 1'b0; step();
        sclk = 1'b0; step();
        check_tails("R4");
    endtask

    initial begin
        #(20ns * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1651));
        rst = 1'b1; par_a = '0; par_b = '0; ser_in = 1'b1;
        load_n = 1'b1; sclk = 1'b1; sclk_en_n = 1'b0;
        step(); step(); step();
        // release reset while gated clock is high
        rst = 1'b0;
        step();
        q_a.delete(); q_b.delete();
        for (int i = 0; i < 8; i++) begin
            q_a.push_back(1'b0);
            q_b.push_back(1'b0);
        end
        check_tails("R10");
        sclk = 1'b0; step();
        for (int i = 0; i < 8; i++) shift_once(0, 1'b0);
        check("R10", tail_b, 1'b0);

        // directed: known byte, clock shifts, zero fill
        do_load(8'hA5, 8'h3C);
        for (int i = 0; i < 16; i++) shift_once(0, 1'b0);
        // directed: enable-edge shifts, ones fill
        do_load(8'h81, 8'h7E);
        for (int i = 0; i < 16; i++) shift_once(1, 1'b1);
        // directed: hold windows
        do_load(8'hC3, 8'h18);
        hold_window(1'b1, 3);
        hold_window(1'b0, 2);

        // random mix
        for (int it = 0; it < 40; it++) begin
            do_load(8'($urandom), 8'($urandom));
            for (int k = 0; k < 16; k++) begin
                int sel;
                sel = int'($urandom_range(0, 3));
                if (sel == 3)
                    hold_window(1'($urandom), int'($urandom_range(1, 3)));
                else
                    shift_once(sel & 1, 1'($urandom));
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule